// File: doc/BRIEF.md
# Bypass Array Multiplier

This block multiplies two unsigned M-bit operands and returns the full 2M-bit product. It is a cell-level array of full adders. One operand, the gating operand, decides which groups of adder cells do any work. When a gating bit is zero, its whole group of M cells is switched off. The cell inputs are forced to constant zero so the adders do not toggle. A bypass multiplexer then forwards the incoming partial sum unchanged and supplies a zero carry.

A parameter picks the orientation:
- Row mode gates on the multiplier bits.
- Column mode gates on the multiplicand bits.

Each group is a ripple row, so the last group also produces the upper product bits. An activity output counts the enabled adder cells for the present operands. A second parameter places a register on both outputs or leaves the path purely combinational.

Top module: `bypass_array_mul`

## Requirements
- R1: For every pair of unsigned operands, the product output equals the operands' product zero-extended to 2M bits, in either orientation.
- R2: With MODE = BYP_ROW, adder group r (1 <= r <= M-1, M cells each) is enabled exactly when multiplier bit r is 1. When disabled, the group forwards the incoming partial sum unchanged and its carry out is 0.
- R3: With MODE = BYP_COL, adder group r is enabled exactly when multiplicand bit r is 1, with the same forwarding behaviour as R2.
- R4: The activity count equals M times the number of ones in bits 1 to M-1 of the gating operand. It therefore lies between 0 and (M-1)*M.
- R5: Bit 0 of the gating operand gates no adder cells. It only masks the first partial product, so it never changes the activity count.
- R6: With REG_OUT = 1, product and count appear on the clock edge after the operands are applied. An active-low asynchronous reset clears both to zero without waiting for a clock edge.
- R7: With REG_OUT = 0, product and count follow the operands combinationally within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | M | Multiplicand |
| b_i | input | M | Multiplier |
| prod_o | output | 2M | Unsigned product |
| active_cnt_o | output | clog2((M-1)*M+1) | Number of enabled adder cells |

## Verification
The following are checked on every clock edge:
- the internal product against the true product;
- the activity count against the gating operand's popcount and its upper bound;
- each adder group against its two roles: forwarding the partial sum untouched when disabled, and adding its shifted partial product when enabled;
- the output stage's one-cycle relation to the array.

Only the bench scenarios show:
- the reset values and the clearing of the outputs by an asynchronous reset in mid-run;
- that gating bit 0 leaves the count alone;
- the two worked operand patterns with mostly-zero gating bits;
- the latency difference between the registered and combinational instances.

// File: rtl/bam_pkg.sv
package bam_pkg;
  typedef enum logic {
    BYP_ROW = 1'b0,
    BYP_COL = 1'b1
  } byp_mode_e;
endpackage

// File: rtl/bam_fa.sv
module bam_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  logic axb;
  assign axb  = a_i ^ b_i;
  assign s_o  = axb ^ c_i;
  assign co_o = (a_i & b_i) | (c_i & axb);
endmodule

// File: rtl/bam_cell.sv
module bam_cell (
  input  logic en_i,
  input  logic x_i,
  input  logic op_i,
  input  logic ci_i,
  output logic s_o,
  output logic co_o,
  output logic act_o
);
  logic x_g, p_g, c_g, fs, fc;

  // isolation: disabled adder sees constant zeros
  assign x_g = x_i  & en_i;
  assign p_g = op_i & en_i;
  assign c_g = ci_i & en_i;

  bam_fa u_fa (
    .a_i (x_g),
    .b_i (p_g),
    .c_i (c_g),
    .s_o (fs),
    .co_o(fc)
  );

  // bypass mux: forward partial sum, kill carry
  assign s_o   = en_i ? fs : x_i;
  assign co_o  = en_i ? fc : 1'b0;
  assign act_o = en_i;
endmodule

// File: rtl/bam_count.sv
module bam_count #(
  parameter int N  = 56,
  parameter int CW = 6
) (
  input  logic [N-1:0]  en_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int k = 0; k < N; k++) cnt_o = cnt_o + CW'(en_i[k]);
  end
endmodule

// File: rtl/bypass_array_mul.sv
module bypass_array_mul
  import bam_pkg::*;
#(
  parameter int        M       = 8,
  parameter byp_mode_e MODE    = BYP_ROW,
  parameter bit        REG_OUT = 1'b1,
  localparam int       W       = 2 * M,
  localparam int       CELLS   = (M - 1) * M,
  localparam int       CW      = $clog2(CELLS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [M-1:0]  a_i,
  input  logic [M-1:0]  b_i,
  output logic [W-1:0]  prod_o,
  output logic [CW-1:0] active_cnt_o
);
  logic [M-1:0]     gate_op, data_op;
  logic [CELLS-1:0] cell_en;
  logic [W-1:0]     prod_c;
  logic [CW-1:0]    cnt_c;

  if (MODE == BYP_ROW) begin : g_row_mode
    assign gate_op = b_i;
    assign data_op = a_i;
  end else begin : g_col_mode
    assign gate_op = a_i;
    assign data_op = b_i;
  end

  for (genvar r = 0; r < M; r++) begin : g_row
    logic [W-1:0] acc;
    if (r == 0) begin : g_base
      // first partial product needs no adders
      assign acc = {{M{1'b0}}, data_op & {M{gate_op[0]}}};
    end else begin : g_add
      logic [W-1:0] prv;
      logic [M-1:0] s;
      assign prv = g_row[r-1].acc;
      for (genvar j = 0; j < M; j++) begin : g_col
        logic ci, co, so;
        if (j == 0) begin : g_c0
          assign ci = 1'b0;
        end else begin : g_cn
          assign ci = g_col[j-1].co;
        end
        bam_cell u_cell (
          .en_i (gate_op[r]),
          .x_i  (prv[r+j]),
          .op_i (data_op[j]),
          .ci_i (ci),
          .s_o  (so),
          .co_o (co),
          .act_o(cell_en[(r-1)*M+j])
        );
        assign s[j] = so;
      end
      if (r + M + 1 < W) begin : g_pad
        assign acc = {{(W-r-M-1){1'b0}}, g_col[M-1].co, s, prv[r-1:0]};
      end else begin : g_top
        assign acc = {g_col[M-1].co, s, prv[r-1:0]};
      end

      // R2
      // row_pass_chk also covers R3 in column orientation
      row_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gate_op[r] |-> acc == prv);
      // R1
      row_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_op[r] |-> acc == prv + (W'(data_op) << r));
    end
  end

  assign prod_c = g_row[M-1].acc;

  bam_count #(.N(CELLS), .CW(CW)) u_cnt (
    .en_i (cell_en),
    .cnt_o(cnt_c)
  );

  if (REG_OUT) begin : g_oreg
    logic [W-1:0]  prod_q;
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prod_q <= '0;
        cnt_q  <= '0;
      end else begin
        prod_q <= prod_c;
        cnt_q  <= cnt_c;
      end
    end
    assign prod_o       = prod_q;
    assign active_cnt_o = cnt_q;

    // R6
    out_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> (prod_o == $past(prod_c)) && (active_cnt_o == $past(cnt_c)));
  end else begin : g_ocomb
    assign prod_o       = prod_c;
    assign active_cnt_o = cnt_c;

    // R7
    out_comb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prod_o == W'(a_i) * W'(b_i));
  end

  // R1
  prod_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_c == W'(a_i) * W'(b_i));
  // R4
  cnt_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_c == CW'(M * $countones(gate_op[M-1:1])));
  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_c <= CW'(CELLS));
endmodule

// File: tb/tb_bypass_array_mul.sv
module tb_bypass_array_mul;
  localparam int BM  = 6;
  localparam int BW  = 2 * BM;
  localparam int BCW = $clog2((BM - 1) * BM + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [BM-1:0]  a_r = '0, b_r = '0;
  logic [BW-1:0]  p_row, p_col;
  logic [BCW-1:0] c_row, c_col;
  int             errors = 0, checks = 0;
  bit             done = 1'b0;

  always #2 clk = ~clk;

  bypass_array_mul #(.M(BM), .MODE(bam_pkg::BYP_ROW), .REG_OUT(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_r), .b_i(b_r),
    .prod_o(p_row), .active_cnt_o(c_row)
  );

  bypass_array_mul #(.M(BM), .MODE(bam_pkg::BYP_COL), .REG_OUT(1'b0)) dut_col (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_r), .b_i(b_r),
    .prod_o(p_col), .active_cnt_o(c_col)
  );

  function automatic int exp_prod(input logic [BM-1:0] a, input logic [BM-1:0] b);
    return int'(a) * int'(b);
  endfunction

  function automatic int exp_cnt(input logic [BM-1:0] g);
    int n = 0;
    for (int k = 1; k < BM; k++) n += int'(g[k]);
    return BM * n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int  prev_p = 0, prev_c = 0;
  bit  prev_v = 1'b0;

  task automatic run(input logic [BM-1:0] a, input logic [BM-1:0] b, input string tag);
    int ep, ecr, ecc;
    @(negedge clk);
    a_r = a;
    b_r = b;
    ep  = exp_prod(a, b);
    ecr = exp_cnt(b);
    ecc = exp_cnt(a);
    #1;
    chk(int'(p_col) == ep, {"R7 col product ", tag}, int'(p_col), ep);
    chk(int'(c_col) == ecc, {"R3 col count ", tag}, int'(c_col), ecc);
    if (prev_v) begin
      chk(int'(p_row) == prev_p, {"R6 latency hold ", tag}, int'(p_row), prev_p);
      chk(int'(c_row) == prev_c, {"R6 count hold ", tag}, int'(c_row), prev_c);
    end
    @(negedge clk);
    chk(int'(p_row) == ep, {"R1 row product ", tag}, int'(p_row), ep);
    chk(int'(c_row) == ecr, {"R2 row count ", tag}, int'(c_row), ecr);
    prev_p = ep;
    prev_c = ecr;
    prev_v = 1'b1;
  endtask

  initial begin
    logic [BM-1:0] ra, rb;
    a_r = 6'h2a;
    b_r = 6'h15;
    repeat (3) @(negedge clk);
    chk(p_row == '0, "R6 reset product", int'(p_row), 0);
    chk(c_row == '0, "R6 reset count", int'(c_row), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run('0, '0, "zero");
    run('1, '1, "all ones");
    chk(int'(c_row) == (BM - 1) * BM, "R4 max count", int'(c_row), (BM - 1) * BM);
    run('1, '0, "b zero");
    chk(c_row == '0, "R4 min count", int'(c_row), 0);
    run('0, '1, "a zero");
    run(6'b001111, 6'b001001, "rows 1,2 bypassed");
    run(6'b001010, 6'b001111, "cols 0,2 zero");
    // R5: only bit 0 set in gating operand
    run(6'b101101, 6'b000001, "R5 b0 only");
    chk(c_row == '0, "R5 row count bit0", int'(c_row), 0);
    chk(int'(p_row) == 45, "R5 row product bit0", int'(p_row), 45);
    run(6'b000001, 6'b110011, "R5 a0 only");
    chk(c_col == '0, "R5 col count bit0", int'(c_col), 0);
    run(6'b100000, 6'b100000, "msb only");

    void'($urandom(32'd1234));
    for (int i = 0; i < 1500; i++) begin
      ra = BM'($urandom);
      rb = BM'($urandom);
      if (i % 7 == 0) rb = rb & BM'($urandom);
      run(ra, rb, "random");
    end

    // R6: asynchronous clear mid-run
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk(p_row == '0, "R6 async clear product", int'(p_row), 0);
    chk(c_row == '0, "R6 async clear count", int'(c_row), 0);
    @(negedge clk);
    rst_n = 1'b1;
    prev_v = 1'b0;
    run(6'b111111, 6'b000110, "after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule